// File: doc/BRIEF.md
# Peripheral Control and Interrupt Register File

This block is the software-visible register file of a peripheral. It answers single-cycle accesses on a plain memory-mapped port: an access strobe, a write/read select, a byte address and a write data word. Read data is registered and appears on the cycle after the read. The block holds four word-aligned 32-bit registers:

- a control word whose enable bits drive dedicated outputs;
- an interrupt status word whose flags are set by hardware and cleared by software;
- an interrupt mask word;
- a read-only debug word that follows two response-status inputs.

Two hardware error sources, one for the write channel and one for the read channel, each raise a sticky status flag. Software clears a flag by writing a 1 to its bit. A flag reaches the single interrupt output only when its mask bit is 1, and the interrupt output is registered. Every bit outside the defined fields reads 0 and ignores writes. Accesses to addresses outside the four registers are harmless.

Top module: `csr_block`

## Requirements
- R1: After reset the control register reads 0x5, and the status, mask and debug registers read 0. The outputs are `mod_en_o`=1, `dbg_en_o`=0, `par_en_o`=1 and `irq_o`=0.
- R2: The control register sits at offset 0x0. Bit 0 is the module enable, bit 1 the debug enable and bit 2 the parity enable. All three are read/write and appear on `mod_en_o`, `dbg_en_o` and `par_en_o` from the cycle after the write.
- R3: Bits outside the defined fields of every register read 0 and are unaffected by writes. For example, writing 0x1234_1234 to control leaves it reading 0x4.
- R4: The interrupt status register sits at offset 0x4. A one-cycle pulse on `err_wr_set_i` sets bit 0 and a pulse on `err_rd_set_i` sets bit 1. A set bit stays set until software clears it.
- R5: Writing 1 to a status bit clears it. Writing 0 to a status bit leaves it unchanged.
- R6: When a hardware set and a write-1 clear reach the same status bit in the same cycle, the bit ends up set.
- R7: The interrupt mask register sits at offset 0x8. Bit 0 masks the write-channel flag and bit 1 masks the read-channel flag. Both bits are read/write and reset to 0.
- R8: `irq_o` is 1 exactly one cycle after any status bit is set together with its mask bit, where a mask bit of 1 lets its flag through. Otherwise `irq_o` is 0.
- R9: The debug register sits at offset 0xC. Bit 0 is `resp_wr_i` and bit 1 is `resp_rd_i`, each sampled every cycle. Bus writes to this register have no effect.
- R10: A read of an unmapped or misaligned address returns 0. A write to such an address changes no register.
- R11: `acc_rdata_o` changes only on the cycle after a read access and holds its value through writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en_i | input | 1 | Access strobe, one access per cycle |
| acc_wr_i | input | 1 | 1 = write, 0 = read |
| acc_addr_i | input | ADDR_W (8) | Byte address |
| acc_wdata_i | input | DATA_W (32) | Write data |
| acc_rdata_o | output | DATA_W (32) | Registered read data |
| err_wr_set_i | input | 1 | Write-channel error set pulse |
| err_rd_set_i | input | 1 | Read-channel error set pulse |
| resp_wr_i | input | 1 | Write response status |
| resp_rd_i | input | 1 | Read response status |
| irq_o | output | 1 | Masked, combined interrupt |
| mod_en_o | output | 1 | Module enable |
| dbg_en_o | output | 1 | Debug enable |
| par_en_o | output | 1 | Parity enable |

## Verification
The bench builds the block with its defaults: a 32-bit data word, an 8-bit address and a control reset value of 0x5. With these defaults, 60 of the 64 word slots and every misaligned byte address are unmapped. The bench uses this to probe 0x10, 0xFC and the misaligned offsets 0x1 and 0x2, and confirms that none of them reads data or aliases onto the control word. The 32-bit data word lets the bench drive all-ones and mixed patterns into every reserved bit.

// File: rtl/csr_pkg.sv
package csr_pkg;
  localparam int NUM_REGS = 4;
  localparam int NUM_SRC  = 2;
  localparam int CTRL_W   = 3;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_ISTS = 2'd1,
    REG_IMSK = 2'd2,
    REG_DBG  = 2'd3
  } reg_idx_e;
endpackage

// File: rtl/csr_decode.sv
module csr_decode #(
  parameter int ADDR_W = 8,
  parameter int NREG   = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NREG-1:0]   hit,
  output logic              miss
);
  localparam int IDX_W = ADDR_W - 2;
  logic aligned;
  assign aligned = (addr[1:0] == 2'b00);
  for (genvar i = 0; i < NREG; i++) begin : g_hit
    assign hit[i] = aligned && (addr[ADDR_W-1:2] == IDX_W'(i));
  end
  assign miss = (hit == '0);
endmodule

// File: rtl/csr_ctrl.sv
module csr_ctrl #(
  parameter int          W   = 3,
  parameter logic [W-1:0] RST = 3'b101
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] ctrl_q
);
  logic [W-1:0] ctrl_d;
  always_comb begin
    ctrl_d = ctrl_q;
    if (we) ctrl_d = wdata;
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= RST;
    else        ctrl_q <= ctrl_d;
  end
  a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(ctrl_q));
  a_r2_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (ctrl_q == $past(wdata)));
endmodule

// File: rtl/csr_irq.sv
module csr_irq #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         sts_we,
  input  logic         msk_we,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] sts_q,
  output logic [N-1:0] msk_q,
  output logic         irq_q
);
  logic [N-1:0] sts_d, msk_d;
  logic         irq_d;

  for (genvar i = 0; i < N; i++) begin : g_src
    always_comb begin
      sts_d[i] = sts_q[i];
      if (sts_we && wdata[i]) sts_d[i] = 1'b0;
      if (set[i])             sts_d[i] = 1'b1;
    end
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> sts_q[i]);
    a_r5_w1c_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_we && wdata[i] && !set[i]) |=> !sts_q[i]);
    a_r5_w0_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_q[i] && !(sts_we && wdata[i])) |=> sts_q[i]);
  end

  always_comb begin
    msk_d = msk_q;
    if (msk_we) msk_d = wdata;
    irq_d = |(sts_q & msk_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      msk_q <= '0;
      irq_q <= 1'b0;
    end else begin
      sts_q <= sts_d;
      msk_q <= msk_d;
      irq_q <= irq_d;
    end
  end

  a_r8_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts_q & msk_q) == '0) |=> !irq_q);
  a_r8_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts_q & msk_q) != '0) |=> irq_q);
endmodule

// File: rtl/csr_dbg.sv
module csr_dbg #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] resp,
  output logic [N-1:0] dbg_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dbg_q <= '0;
    else        dbg_q <= resp;
  end
  a_r9_dbg_track: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(resp) |=> $stable(dbg_q) || (dbg_q == resp));
endmodule

// File: rtl/csr_block.sv
module csr_block
  import csr_pkg::*;
#(
  parameter int                 DATA_W   = 32,
  parameter int                 ADDR_W   = 8,
  parameter logic [CTRL_W-1:0]  CTRL_RST = 3'b101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en_i,
  input  logic              acc_wr_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [DATA_W-1:0] acc_wdata_i,
  output logic [DATA_W-1:0] acc_rdata_o,
  input  logic              err_wr_set_i,
  input  logic              err_rd_set_i,
  input  logic              resp_wr_i,
  input  logic              resp_rd_i,
  output logic              irq_o,
  output logic              mod_en_o,
  output logic              dbg_en_o,
  output logic              par_en_o
);
  logic [NUM_REGS-1:0] hit;
  logic                miss;
  logic                wr_acc, rd_acc;
  logic [CTRL_W-1:0]   ctrl_q;
  logic [NUM_SRC-1:0]  sts_q, msk_q, dbg_q;
  logic [DATA_W-1:0]   rdata_d, rdata_q;
  logic                unused_wdata;

  assign unused_wdata = ^acc_wdata_i[DATA_W-1:CTRL_W];
  assign wr_acc = acc_en_i && acc_wr_i;
  assign rd_acc = acc_en_i && !acc_wr_i;

  csr_decode #(.ADDR_W(ADDR_W), .NREG(NUM_REGS)) u_dec (
    .addr(acc_addr_i), .hit(hit), .miss(miss)
  );

  csr_ctrl #(.W(CTRL_W), .RST(CTRL_RST)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .we(wr_acc && hit[REG_CTRL]),
    .wdata(acc_wdata_i[CTRL_W-1:0]),
    .ctrl_q(ctrl_q)
  );

  csr_irq #(.N(NUM_SRC)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .set({err_rd_set_i, err_wr_set_i}),
    .sts_we(wr_acc && hit[REG_ISTS]),
    .msk_we(wr_acc && hit[REG_IMSK]),
    .wdata(acc_wdata_i[NUM_SRC-1:0]),
    .sts_q(sts_q), .msk_q(msk_q), .irq_q(irq_o)
  );

  csr_dbg #(.N(NUM_SRC)) u_dbg (
    .clk(clk), .rst_n(rst_n),
    .resp({resp_rd_i, resp_wr_i}),
    .dbg_q(dbg_q)
  );

  always_comb begin
    rdata_d = '0;
    unique case (1'b1)
      hit[REG_CTRL]: rdata_d[CTRL_W-1:0]  = ctrl_q;
      hit[REG_ISTS]: rdata_d[NUM_SRC-1:0] = sts_q;
      hit[REG_IMSK]: rdata_d[NUM_SRC-1:0] = msk_q;
      hit[REG_DBG]:  rdata_d[NUM_SRC-1:0] = dbg_q;
      default:       rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (rd_acc) rdata_q <= rdata_d;
  end

  assign acc_rdata_o = rdata_q;
  assign mod_en_o    = ctrl_q[0];
  assign dbg_en_o    = ctrl_q[1];
  assign par_en_o    = ctrl_q[2];

  a_r10_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && miss) |=> (acc_rdata_o == '0));
  a_r10_miss_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && miss && !err_wr_set_i && !err_rd_set_i) |=>
      ($stable(ctrl_q) && $stable(sts_q) && $stable(msk_q)));
  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_acc |=> $stable(acc_rdata_o));
  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> (acc_rdata_o[DATA_W-1:CTRL_W] == '0));
endmodule

// File: tb/sim_csr_block.sv
module sim_csr_block;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_en, acc_wr;
  logic [7:0]  acc_addr;
  logic [31:0] acc_wdata, acc_rdata;
  logic        err_wr, err_rd, resp_wr, resp_rd;
  logic        irq, mod_en, dbg_en, par_en;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          done = 1'b0;

  always #5 clk = ~clk;

  csr_block u0 (
    .clk(clk), .rst_n(rst_n),
    .acc_en_i(acc_en), .acc_wr_i(acc_wr), .acc_addr_i(acc_addr),
    .acc_wdata_i(acc_wdata), .acc_rdata_o(acc_rdata),
    .err_wr_set_i(err_wr), .err_rd_set_i(err_rd),
    .resp_wr_i(resp_wr), .resp_rd_i(resp_rd),
    .irq_o(irq), .mod_en_o(mod_en), .dbg_en_o(dbg_en), .par_en_o(par_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b0; acc_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    acc_en = 1'b0;
  endtask

  task automatic pulse(input logic w, input logic r);
    @(negedge clk);
    err_wr = w; err_rd = r;
    @(negedge clk);
    err_wr = 1'b0; err_rd = 1'b0;
  endtask

  // monitor: pops the expected word one edge after each read
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && acc_en && !acc_wr) begin
        @(negedge clk);
        if (exp_q.size() == 0) chk("monitor-unexpected", 32'h1, 32'h0);
        else chk(tag_q.pop_front(), acc_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; acc_en = 1'b0; acc_wr = 1'b0; acc_addr = '0; acc_wdata = '0;
    err_wr = 1'b0; err_rd = 1'b0; resp_wr = 1'b0; resp_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mod_en", {31'b0, mod_en}, 32'h1);
    chk("R1 dbg_en", {31'b0, dbg_en}, 32'h0);
    chk("R1 par_en", {31'b0, par_en}, 32'h1);
    chk("R1 irq",    {31'b0, irq},    32'h0);
    rd(8'h00, 32'h5, "R1 ctrl reset");
    rd(8'h04, 32'h0, "R1 status reset");
    rd(8'h08, 32'h0, "R1 mask reset R7");
    rd(8'h0C, 32'h0, "R1 debug reset");
    // R2 / R3 control
    wr(8'h00, 32'h1234_1234);
    rd(8'h00, 32'h4, "R3 ctrl reserved masked");
    chk("R2 mod_en after write", {31'b0, mod_en}, 32'h0);
    chk("R2 par_en after write", {31'b0, par_en}, 32'h1);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, 32'h7, "R2 ctrl all ones");
    chk("R2 dbg_en set", {31'b0, dbg_en}, 32'h1);
    // R7 mask
    wr(8'h08, 32'hFFFF_FFFC);
    rd(8'h08, 32'h0, "R3 mask reserved");
    wr(8'h08, 32'h3);
    rd(8'h08, 32'h3, "R7 mask rw");
    // R4 / R8 set and interrupt
    pulse(1'b1, 1'b0);
    @(negedge clk);
    chk("R8 irq raised", {31'b0, irq}, 32'h1);
    rd(8'h04, 32'h1, "R4 write-channel flag");
    wr(8'h04, 32'hFFFF_FFFE);
    rd(8'h04, 32'h1, "R5 write0 keeps");
    wr(8'h04, 32'h1);
    @(negedge clk);
    chk("R8 irq cleared", {31'b0, irq}, 32'h0);
    rd(8'h04, 32'h0, "R5 w1c clears");
    // masked source
    wr(8'h08, 32'h1);
    pulse(1'b0, 1'b1);
    @(negedge clk);
    chk("R8 irq masked", {31'b0, irq}, 32'h0);
    rd(8'h04, 32'h2, "R4 read-channel flag");
    wr(8'h08, 32'h2);
    @(negedge clk);
    chk("R8 irq unmasked", {31'b0, irq}, 32'h1);
    wr(8'h04, 32'h2);
    rd(8'h04, 32'h0, "R5 clear bit1");
    // R6 set wins
    @(negedge clk);
    err_wr = 1'b1; acc_en = 1'b1; acc_wr = 1'b1; acc_addr = 8'h04; acc_wdata = 32'h1;
    @(negedge clk);
    err_wr = 1'b0; acc_en = 1'b0; acc_wr = 1'b0;
    rd(8'h04, 32'h1, "R6 set beats clear");
    wr(8'h04, 32'h3);
    rd(8'h04, 32'h0, "R5 clear both");
    // R9 debug
    @(negedge clk); resp_wr = 1'b1; resp_rd = 1'b0;
    rd(8'h0C, 32'h1, "R9 debug write resp");
    wr(8'h0C, 32'hFFFF_FFFE);
    rd(8'h0C, 32'h1, "R9 debug ignores write");
    @(negedge clk); resp_rd = 1'b1;
    rd(8'h0C, 32'h3, "R9 debug both");
    // R11 hold
    wr(8'h00, 32'h0);
    repeat (2) @(negedge clk);
    chk("R11 rdata held", acc_rdata, 32'h3);
    // R10 unmapped
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, 32'h0, "R10 unmapped read");
    rd(8'h02, 32'h0, "R10 misaligned read");
    wr(8'h01, 32'hFFFF_FFFF);
    wr(8'hFC, 32'hFFFF_FFFF);
    rd(8'hFC, 32'h0, "R10 top slot");
    rd(8'h00, 32'h0, "R10 no alias onto ctrl");
    rd(8'h08, 32'h2, "R10 mask untouched");
    repeat (3) @(negedge clk);
    chk("R10 queue drained", exp_q.size(), 32'h0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule